// File: doc/BRIEF.md
# Serial Configuration Chain

This block holds the configuration word of a reconfigurable logic block in one continuous shift register. A host loads it serially, one bit per configuration clock, least significant bit first. The bits that fall out of the far end appear on a serial output, so the configuration already held can be read back while a new one goes in. The whole register is also presented in parallel to the logic it configures.

A configuration-mode input brackets every load. While it is high, the parallel outputs read as all zero so the configured logic sees no glitches from partly loaded words. As soon as it drops, the loaded word drives the parallel outputs. While it is low, the register cannot change.

A parameter picks how a bit is advanced. In system-clock mode the register runs on the system clock and a shift enable decides which edges move a bit. In gated-clock mode the register runs on a dedicated configuration clock that is gated outside the block; every edge of that clock moves a bit and the shift enable is ignored. Several instances may share configuration mode and be loaded one after another, because an instance that gets no enable or clock edge keeps its contents.

Top module: `cfg_chain`

## Requirements
- R1: After synchronous reset (`rst` high over a clock edge of the shifting clock) every chain bit is 0, so `cfg_bits` and `cfg_dout` read 0.
- R2: In system-clock mode, each rising `clk` edge with `cfg_mode` and `cfg_shift` both high moves the chain one place toward bit 0 and takes `cfg_din` into bit CHAIN_LEN-1; after CHAIN_LEN such edges, the bit supplied k-th (counting from 0) sits in bit k of the chain.
- R3: `cfg_dout` is always chain bit 0, so during a load of CHAIN_LEN bits the previous word emerges on `cfg_dout` lowest bit first, bit k being visible just before the k-th shifting edge.
- R4: While `cfg_mode` is high, `cfg_bits` is all zero.
- R5: While `cfg_mode` is low, `cfg_bits` equals the chain, in the same cycle in which `cfg_mode` falls.
- R6: In system-clock mode, a `clk` edge with `cfg_mode` high and `cfg_shift` low leaves the chain unchanged.
- R7: While `cfg_mode` is low, no clock edge changes the chain, whatever `cfg_shift`, `cfg_din` or `cfg_clk` do.
- R8: In gated-clock mode, each rising `cfg_clk` edge with `cfg_mode` high shifts one bit as in R2 whatever `cfg_shift` is, and `clk` edges never shift.
- R9: An instance that receives no shift enable (system mode) or no `cfg_clk` edge (gated mode) keeps its word while another instance sharing its mode line is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; shifting clock in system-clock mode |
| rst | input | 1 | Synchronous active-high reset, sampled by the shifting clock |
| cfg_mode | input | 1 | High while configuration is being loaded or read back |
| cfg_shift | input | 1 | Shift enable, used in system-clock mode only |
| cfg_clk | input | 1 | Gated configuration clock, used in gated-clock mode only |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial data out, chain bit 0 |
| cfg_bits | output | CHAIN_LEN | Parallel configuration word, zero during configuration mode |

## Verification
On every edge of the shifting clock the assertions check that an advancing edge moves the chain by exactly one place with the new bit at the top and the old bit 1 landing on the serial output, that a non-advancing edge keeps the chain, that the chain is frozen whenever configuration mode is low, and that the parallel outputs are zero under configuration mode. The bench alone can show that a full word ends up in bit order with the first bit supplied at bit 0, that the word read back serially equals the word loaded before, that the parallel output switches to the new word as soon as mode falls, and that a second instance on its own clock keeps its word while the first one loads; it sweeps every word of an 8-bit chain in both clock variants.

// File: rtl/cfgchain_pkg.sv
package cfgchain_pkg;

  // How the chain is advanced
  typedef enum logic {
    SHIFT_ON_SYSCLK   = 1'b0,  // system clock qualified by the shift enable
    SHIFT_ON_GATEDCLK = 1'b1   // every edge of an externally gated clock
  } shift_clk_e;

endpackage

// File: rtl/cfgchain_advance.sv
module cfgchain_advance
  import cfgchain_pkg::*;
#(
  parameter shift_clk_e CLK_SEL = SHIFT_ON_SYSCLK
) (
  input  logic cfg_mode,
  input  logic cfg_shift,
  output logic step
);

  generate
    if (CLK_SEL == SHIFT_ON_SYSCLK) begin : g_sys
      // enable qualifies the free-running clock
      assign step = cfg_mode & cfg_shift;
    end else begin : g_gated
      // every delivered edge counts; enable is not looked at
      logic unused_shift_en;
      assign unused_shift_en = cfg_shift;
      assign step = cfg_mode;
    end
  endgenerate

endmodule

// File: rtl/cfgchain_store.sv
module cfgchain_store
  import cfgchain_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 24,
  parameter shift_clk_e  CLK_SEL   = SHIFT_ON_SYSCLK
) (
  input  logic                 clk,
  input  logic                 cfg_clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic                 din,
  output logic [CHAIN_LEN-1:0] chain_q,
  output logic                 dout
);

  localparam int unsigned TOP = CHAIN_LEN - 1;

  logic [CHAIN_LEN-1:0] chain_d;

  // one place toward bit 0, new bit enters at the top
  assign chain_d = step ? {din, chain_q[TOP:1]} : chain_q;
  assign dout    = chain_q[0];

  generate
    if (CLK_SEL == SHIFT_ON_SYSCLK) begin : g_sys
      logic unused_gclk;
      assign unused_gclk = cfg_clk;

      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
      end

      // R2
      shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> (chain_q[TOP] == $past(din)) && (chain_q[TOP-1:0] == $past(chain_q[TOP:1])));
      // R6
      hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(chain_q));
      // R3
      dout_follows_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> dout == $past(chain_q[1]));
    end else begin : g_gated
      logic unused_sclk;
      assign unused_sclk = clk;

      always_ff @(posedge cfg_clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
      end

      // R8
      shift_move_chk: assert property (@(posedge cfg_clk) disable iff (rst)
        step |=> (chain_q[TOP] == $past(din)) && (chain_q[TOP-1:0] == $past(chain_q[TOP:1])));
      // R7
      hold_when_idle_chk: assert property (@(posedge cfg_clk) disable iff (rst)
        !step |=> $stable(chain_q));
      // R3
      dout_follows_chk: assert property (@(posedge cfg_clk) disable iff (rst)
        step |=> dout == $past(chain_q[1]));
    end
  endgenerate

endmodule

// File: rtl/cfgchain_mask.sv
module cfgchain_mask #(
  parameter int unsigned CHAIN_LEN = 24
) (
  input  logic                 hold_zero,
  input  logic [CHAIN_LEN-1:0] word_in,
  output logic [CHAIN_LEN-1:0] word_out
);

  // per-bit gate so every configured signal is forced low during loading
  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_bit
    assign word_out[i] = word_in[i] & ~hold_zero;
  end

endmodule

// File: rtl/cfg_chain.sv
module cfg_chain
  import cfgchain_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 24,
  parameter shift_clk_e  CLK_SEL   = SHIFT_ON_SYSCLK
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_mode,
  input  logic                 cfg_shift,
  input  logic                 cfg_clk,
  input  logic                 cfg_din,
  output logic                 cfg_dout,
  output logic [CHAIN_LEN-1:0] cfg_bits
);

  logic                 step;
  logic [CHAIN_LEN-1:0] chain_q;

  cfgchain_advance #(
    .CLK_SEL (CLK_SEL)
  ) u_adv (
    .cfg_mode  (cfg_mode),
    .cfg_shift (cfg_shift),
    .step      (step)
  );

  cfgchain_store #(
    .CHAIN_LEN (CHAIN_LEN),
    .CLK_SEL   (CLK_SEL)
  ) u_store (
    .clk     (clk),
    .cfg_clk (cfg_clk),
    .rst     (rst),
    .step    (step),
    .din     (cfg_din),
    .chain_q (chain_q),
    .dout    (cfg_dout)
  );

  cfgchain_mask #(
    .CHAIN_LEN (CHAIN_LEN)
  ) u_mask (
    .hold_zero (cfg_mode),
    .word_in   (chain_q),
    .word_out  (cfg_bits)
  );

  generate
    if (CLK_SEL == SHIFT_ON_SYSCLK) begin : g_chk_sys
      // R7
      frozen_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_mode |=> $stable(chain_q));
      // R4
      zero_in_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_mode |-> cfg_bits == '0);
    end else begin : g_chk_gated
      // R7
      frozen_in_run_chk: assert property (@(posedge cfg_clk) disable iff (rst)
        !cfg_mode |=> $stable(chain_q));
      // R4
      zero_in_cfg_chk: assert property (@(posedge cfg_clk) disable iff (rst)
        cfg_mode |-> cfg_bits == '0);
    end
  endgenerate

endmodule

// File: tb/sim_cfg_chain.sv
module sim_cfg_chain;
  import cfgchain_pkg::*;

  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  // u0: system-clock variant
  logic         mode0 = 1'b0, shift0 = 1'b0, din0 = 1'b0;
  logic         dout0;
  logic [N-1:0] bits0;
  // u1: gated-clock variant
  logic         mode1 = 1'b0, shift1 = 1'b0, din1 = 1'b0, gclk = 1'b0;
  logic         dout1;
  logic [N-1:0] bits1;

  cfg_chain #(.CHAIN_LEN(N), .CLK_SEL(SHIFT_ON_SYSCLK)) u0 (
    .clk(clk), .rst(rst), .cfg_mode(mode0), .cfg_shift(shift0), .cfg_clk(1'b0),
    .cfg_din(din0), .cfg_dout(dout0), .cfg_bits(bits0));

  cfg_chain #(.CHAIN_LEN(N), .CLK_SEL(SHIFT_ON_GATEDCLK)) u1 (
    .clk(clk), .rst(rst), .cfg_mode(mode1), .cfg_shift(shift1), .cfg_clk(gclk),
    .cfg_din(din1), .cfg_dout(dout1), .cfg_bits(bits1));

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic gpulse();
    gclk = 1'b1; #2;
    gclk = 1'b0; #2;
  endtask

  // system-mode load of a full word, returns what came out serially
  task automatic load0(input logic [N-1:0] w, output logic [N-1:0] old);
    @(negedge clk);
    mode0 = 1'b1;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      din0 = w[i]; shift0 = 1'b1;
      #1 old[i] = dout0;
    end
    @(negedge clk);
    shift0 = 1'b0;
  endtask

  // gated-mode load, shift enable deliberately held low
  task automatic load1(input logic [N-1:0] w, output logic [N-1:0] old);
    mode1 = 1'b1; shift1 = 1'b0; #1;
    for (int i = 0; i < N; i++) begin
      din1 = w[i]; #1;
      old[i] = dout1;
      gpulse();
    end
  endtask

  initial begin
    logic [N-1:0] old, prev;
    // reset over clk and gated clock edges
    repeat (3) @(negedge clk);
    gpulse(); gpulse();
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 bits0", bits0, '0);
    chk("R1 bits1", bits1, '0);
    chk("R1 dout0", {{(N-1){1'b0}}, dout0}, '0);
    chk("R1 dout1", {{(N-1){1'b0}}, dout1}, '0);

    // R2/R3/R4/R5 on u0
    load0(8'hB4, old);
    #1;
    chk("R4 zero during mode", bits0, '0);
    chk("R3 readback after reset", old, '0);
    mode0 = 1'b0; #0.5;
    chk("R5 word visible at mode fall", bits0, 8'hB4);
    chk("R9 u1 untouched by u0 load", bits1, '0);

    // R6: mode high, enable low, clocks run
    @(negedge clk); mode0 = 1'b1; din0 = 1'b1; shift0 = 1'b0;
    repeat (5) @(negedge clk);
    mode0 = 1'b0; #1;
    chk("R6 no shift without enable", bits0, 8'hB4);

    // R7: mode low, enable and data toggling
    shift0 = 1'b1;
    for (int i = 0; i < 6; i++) begin @(negedge clk); din0 = i[0]; end
    #1;
    chk("R7 frozen in run mode u0", bits0, 8'hB4);
    @(negedge clk); shift0 = 1'b0;

    // exhaustive sweep on u0
    prev = 8'hB4;
    for (int p = 0; p < 256; p++) begin
      load0(p[N-1:0], old);
      chk("R3 sweep readback u0", old, prev);
      mode0 = 1'b0; #1;
      chk("R2 sweep word u0", bits0, p[N-1:0]);
      prev = p[N-1:0];
    end

    // gated variant
    load1(8'h3C, old);
    chk("R4 zero during mode u1", bits1, '0);
    chk("R8 readback after reset u1", old, '0);
    mode1 = 1'b0; #0.5;
    chk("R5 word visible u1", bits1, 8'h3C);
    chk("R9 u0 untouched by u1 load", bits0, 8'hFF);

    // R8: clk edges with mode high and enable high do not shift u1
    mode1 = 1'b1; shift1 = 1'b1; din1 = 1'b1;
    repeat (6) @(negedge clk);
    mode1 = 1'b0; shift1 = 1'b0; #1;
    chk("R8 clk does not shift u1", bits1, 8'h3C);

    // R7: gated edges with mode low
    din1 = 1'b1; shift1 = 1'b1;
    for (int i = 0; i < 5; i++) gpulse();
    shift1 = 1'b0; #1;
    chk("R7 frozen in run mode u1", bits1, 8'h3C);

    prev = 8'h3C;
    for (int p = 255; p >= 0; p--) begin
      load1(p[N-1:0], old);
      chk("R8 sweep readback u1", old, prev);
      mode1 = 1'b0; #1;
      chk("R8 sweep word u1", bits1, p[N-1:0]);
      prev = p[N-1:0];
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule